// File: doc/BRIEF.md
# Triggered Sample Output Path for a DAC

This block is the digital front end of a sample-playback converter. Software or a transfer engine writes each audio sample into a staging (holding) register. The sample may come in one of three formats, and the block converts every format to a single 12-bit code as it stores it. A trigger copies the staged code into an output register, and that register drives the converter's code bus. Between triggers the code bus does not move, however often the staging register is rewritten.

The trigger can come from three places. The first is a built-in sample-rate tick, made by a prescaler feeding an auto-reload counter. The second is an external trigger pin. The third is a software strobe. A select field chooses which hardware source is active. Each hardware-triggered copy can raise a next-sample request, which asks the transfer engine for the following sample. The next accepted write acknowledges that request. If a hardware trigger arrives while a request is still unanswered, the block flags an underrun and presents the unchanged staged value again. A software-triggered copy never raises a request. The tick period is (psc+1)·(arr+1) clock cycles. With psc held at 0, arr alone sets the sample rate: for example, arr = f_clk/22050 − 1 gives 22.05 kHz.

Top module: `dac_trig_path`

## Requirements
- R1: After reset, dac_code is 0, req is 0, underrun is 0 and tick is 0. The staging register is also 0, so a software trigger straight after reset leaves dac_code at 0.
- R2: A write with wr_fmt=0 takes an 8-bit sample from wr_data[7:0] and places it in code bits [11:4], with zeros in bits [3:0]. wr_fmt=1 takes a right-aligned 12-bit sample from wr_data[11:0]. wr_fmt=2 takes a left-aligned 12-bit sample from wr_data[15:4].
- R3: A write with wr_fmt=3 is ignored. It changes neither the staging register nor the request.
- R4: dac_code changes only on a clock edge at which a trigger is present. After that edge it shows the staging value from before the edge. A write in the same cycle as the trigger reaches dac_code only at a later trigger.
- R5: A hardware trigger with req_en=1 drives req high from the next cycle. With req_en=0, a hardware trigger leaves req unchanged.
- R6: sw_trig copies the staging register to dac_code but never raises req.
- R7: req stays high until an accepted write (wr_fmt 0 to 2) clears it in the following cycle. If a hardware trigger with req_en=1 falls in the same cycle as that write, req stays high.
- R8: A hardware trigger while req is high and no accepted write is present sets underrun. underrun stays set until reset. dac_code is then reloaded with the unchanged staging value.
- R9: While tick_en=1, tick is a one-cycle pulse every (psc+1)·(arr+1) cycles. While tick_en=0, tick stays 0 and the counters return to zero.
- R10: The trigger select works as follows. trig_sel=0 uses tick as the hardware trigger. trig_sel=1 uses ext_trig. trig_sel=2 or 3 disables hardware triggers, so only sw_trig moves data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Runs the sample-rate counter |
| psc | input | 16 | Prescaler limit (divide by psc+1) |
| arr | input | 16 | Auto-reload limit (divide by arr+1) |
| trig_sel | input | 2 | Hardware trigger source: 0 tick, 1 ext_trig, 2/3 none |
| ext_trig | input | 1 | External trigger pulse |
| sw_trig | input | 1 | Software trigger strobe |
| wr_en | input | 1 | Staging register write strobe |
| wr_fmt | input | 2 | Write format: 0 8-bit, 1 12-bit right, 2 12-bit left, 3 ignored |
| wr_data | input | 16 | Write data |
| req_en | input | 1 | Allows hardware triggers to raise req |
| dac_code | output | 12 | Output register driving the converter code bus |
| req | output | 1 | Next-sample request |
| underrun | output | 1 | Sticky flag: trigger while request unanswered |
| tick | output | 1 | Sample-rate tick pulse |

## Verification
Several of the block's functions can meet in the same cycle. The one the bench drives deliberately is a staging write landing in the same cycle as a hardware trigger. When that happens, the copy must take the old staged value, the new value must wait for the next trigger, and the write's acknowledge must lose to the new request. The bench sets this up by raising ext_trig and wr_en on one edge. It then checks dac_code, req and underrun against values worked out from the pre-edge staging contents. A further trigger with no write must then flag an underrun and present the value written earlier.

// File: rtl/dac_trig_pkg.sv
`timescale 1ns/1ps
package dac_trig_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NARROW_W = 8;

  typedef enum logic [1:0] {
    FMT_R8  = 2'd0,
    FMT_R12 = 2'd1,
    FMT_L12 = 2'd2,
    FMT_BAD = 2'd3
  } wr_fmt_e;

  typedef enum logic [1:0] {
    SRC_TICK = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_OFF2 = 2'd2,
    SRC_OFF3 = 2'd3
  } trig_src_e;
endpackage

// File: rtl/dac_tick_gen.sv
`timescale 1ns/1ps
module dac_tick_gen #(
  parameter int unsigned PSC_W = 16,
  parameter int unsigned ARR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  input  logic [ARR_W-1:0] arr,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt_q, pcnt_d;
  logic [ARR_W-1:0] acnt_q, acnt_d;
  logic             tick_q, tick_d;
  logic             p_wrap, a_wrap;

  assign p_wrap = (pcnt_q == psc);
  assign a_wrap = (acnt_q == arr);

  always_comb begin
    pcnt_d = '0;
    acnt_d = '0;
    tick_d = 1'b0;
    if (en) begin
      pcnt_d = p_wrap ? '0 : pcnt_q + 1'b1;
      acnt_d = acnt_q;
      if (p_wrap) begin
        acnt_d = a_wrap ? '0 : acnt_q + 1'b1;
      end
      tick_d = p_wrap && a_wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      acnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      acnt_q <= acnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/dac_fmt_norm.sv
`timescale 1ns/1ps
module dac_fmt_norm
  import dac_trig_pkg::*;
(
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] din,
  output logic [CODE_W-1:0] code,
  output logic              fmt_ok
);
  localparam int unsigned PAD_W = CODE_W - NARROW_W;

  always_comb begin
    code   = '0;
    fmt_ok = 1'b1;
    unique case (wr_fmt_e'(fmt))
      FMT_R8:  code = {din[NARROW_W-1:0], {PAD_W{1'b0}}};
      FMT_R12: code = din[CODE_W-1:0];
      FMT_L12: code = din[DATA_W-1 -: CODE_W];
      default: fmt_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/dac_trig_path.sv
`timescale 1ns/1ps
module dac_trig_path
  import dac_trig_pkg::*;
#(
  parameter int unsigned PSC_W = 16,
  parameter int unsigned ARR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [PSC_W-1:0]  psc,
  input  logic [ARR_W-1:0]  arr,
  input  logic [1:0]        trig_sel,
  input  logic              ext_trig,
  input  logic              sw_trig,
  input  logic              wr_en,
  input  logic [1:0]        wr_fmt,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_en,
  output logic [CODE_W-1:0] dac_code,
  output logic              req,
  output logic              underrun,
  output logic              tick
);
  logic              rsync_q1, rst_sync_n;
  logic [CODE_W-1:0] norm_code;
  logic              fmt_ok, wr_ack, hw_trig, any_trig;
  logic [CODE_W-1:0] hold_q, hold_d, out_q, out_d;
  logic              req_q, req_d, unr_q, unr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q1   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rsync_q1   <= 1'b1;
      rst_sync_n <= rsync_q1;
    end
  end

  dac_tick_gen #(.PSC_W(PSC_W), .ARR_W(ARR_W)) i_tick (
    .clk(clk), .rst_n(rst_sync_n), .en(tick_en),
    .psc(psc), .arr(arr), .tick(tick)
  );

  dac_fmt_norm i_norm (
    .fmt(wr_fmt), .din(wr_data), .code(norm_code), .fmt_ok(fmt_ok)
  );

  always_comb begin
    unique case (trig_src_e'(trig_sel))
      SRC_TICK: hw_trig = tick;
      SRC_EXT:  hw_trig = ext_trig;
      default:  hw_trig = 1'b0;
    endcase
  end

  assign wr_ack   = wr_en && fmt_ok;
  assign any_trig = hw_trig || sw_trig;

  always_comb begin
    hold_d = wr_ack ? norm_code : hold_q;
    out_d  = any_trig ? hold_q : out_q;
    req_d  = req_q;
    if (wr_ack) req_d = 1'b0;
    if (hw_trig && req_en) req_d = 1'b1;
    unr_d  = unr_q || (hw_trig && req_q && !wr_ack);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_q <= '0;
      out_q  <= '0;
      req_q  <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      out_q  <= out_d;
      req_q  <= req_d;
      unr_q  <= unr_d;
    end
  end

  assign dac_code = out_q;
  assign req      = req_q;
  assign underrun = unr_q;
endmodule

// File: rtl/dac_trig_path_chk.sv
`timescale 1ns/1ps
module dac_trig_path_chk #(
  parameter int unsigned CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_trig,
  input logic              sw_trig,
  input logic              wr_ack,
  input logic              req_en,
  input logic              tick_en,
  input logic              tick,
  input logic              req,
  input logic              underrun,
  input logic [CODE_W-1:0] dac_code
);
  a_r4_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_trig && !sw_trig) |=> $stable(dac_code));

  a_r5_req_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_trig && req_en) |=> req);

  a_r6_sw_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig && !hw_trig && !req) |=> !req);

  a_r7_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr_ack) |=> req);

  a_r8_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_trig && req && !wr_ack) |=> underrun);

  a_r8_underrun_keep: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  a_r9_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !tick);
endmodule

bind dac_trig_path dac_trig_path_chk #(.CODE_W(dac_trig_pkg::CODE_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .hw_trig(hw_trig), .sw_trig(sw_trig),
  .wr_ack(wr_ack), .req_en(req_en), .tick_en(tick_en), .tick(tick),
  .req(req), .underrun(underrun), .dac_code(dac_code)
);

// File: tb/test_dac_trig_path.sv
`timescale 1ns/1ps
module test_dac_trig_path;
  logic clk = 1'b0;
  logic rst_n;
  logic tick_en, ext_trig, sw_trig, wr_en, req_en;
  logic [15:0] psc, arr, wr_data;
  logic [1:0]  trig_sel, wr_fmt;
  logic [11:0] dac_code;
  logic req, underrun, tick;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dac_trig_path i_dac_trig_path (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psc(psc), .arr(arr),
    .trig_sel(trig_sel), .ext_trig(ext_trig), .sw_trig(sw_trig),
    .wr_en(wr_en), .wr_fmt(wr_fmt), .wr_data(wr_data), .req_en(req_en),
    .dac_code(dac_code), .req(req), .underrun(underrun), .tick(tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] f, input logic [15:0] d);
    wr_en = 1'b1; wr_fmt = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic swt();
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  task automatic ext(input bit with_wr, input logic [15:0] d);
    ext_trig = 1'b1;
    if (with_wr) begin wr_en = 1'b1; wr_fmt = 2'd1; wr_data = d; end
    @(negedge clk);
    ext_trig = 1'b0; wr_en = 1'b0;
  endtask

  function automatic int norm(input int f, input int d);
    if (f == 0) return (d & 8'hFF) * 16;
    if (f == 1) return d & 12'hFFF;
    return (d >> 4) & 12'hFFF;
  endfunction

  initial begin
    #500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int last;
    int n;
    rst_n = 1'b0; tick_en = 0; ext_trig = 0; sw_trig = 0; wr_en = 0;
    req_en = 0; psc = 0; arr = 0; wr_data = 0; trig_sel = 2'd2; wr_fmt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 code", dac_code, 0);
    chk("R1 req", req, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 tick", tick, 0);
    swt();
    chk("R1 staging zero", dac_code, 0);

    // R2 format sweep, R4 no change before trigger, R6 no request
    last = 0;
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 64; k++) begin
        int d;
        d = (k * 16'h0A3B + f * 16'h1357) & 16'hFFFF;
        wr(f[1:0], d[15:0]);
        chk("R4 write alone", dac_code, last);
        swt();
        chk("R2 format", dac_code, norm(f, d));
        chk("R6 sw no req", req, 0);
        last = norm(f, d);
      end
    end

    // R3 reserved format ignored
    wr(2'd1, 16'h0123);
    swt();
    wr(2'd3, 16'hFFFF);
    swt();
    chk("R3 ignored write", dac_code, 12'h123);

    // R10 ext source, R5 request
    trig_sel = 2'd1; req_en = 1'b1;
    wr(2'd1, 16'h0055);
    ext(0, 0);
    chk("R10 ext transfer", dac_code, 12'h055);
    chk("R5 req raised", req, 1);
    wr(2'd1, 16'h00AA);
    chk("R7 ack clears", req, 0);
    chk("R4 held", dac_code, 12'h055);
    req_en = 1'b0;
    ext(0, 0);
    chk("R5 req_en off transfer", dac_code, 12'h0AA);
    chk("R5 req_en off no req", req, 0);

    // same-cycle trigger and write, then underrun
    req_en = 1'b1;
    ext(1, 16'h0011);
    chk("R4 same cycle old value", dac_code, 12'h0AA);
    chk("R5 req after ext", req, 1);
    ext(1, 16'h0022);
    chk("R7 set wins over ack", req, 1);
    chk("R8 no underrun with ack", underrun, 0);
    chk("R4 second old value", dac_code, 12'h011);
    ext(0, 0);
    chk("R8 underrun set", underrun, 1);
    chk("R8 re-present", dac_code, 12'h022);
    chk("R7 req still", req, 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", underrun, 1);

    // R10 disabled hardware source
    req_en = 1'b0;
    wr(2'd1, 16'h0777);
    trig_sel = 2'd2;
    ext(0, 0);
    chk("R10 sel2 ignores ext", dac_code, 12'h022);
    trig_sel = 2'd3;
    ext(0, 0);
    chk("R10 sel3 ignores ext", dac_code, 12'h022);

    // R10 ext selected: tick does not transfer
    trig_sel = 2'd1; psc = 0; arr = 2; tick_en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 tick ignored under ext", dac_code, 12'h022);
    tick_en = 1'b0;
    @(negedge clk);

    // R9 idle tick
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk("R9 idle tick", tick, 0);
    end

    // R9 period sweep, R10 tick source
    trig_sel = 2'd0;
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 5; a++) begin
        tick_en = 1'b0; psc = p[15:0]; arr = a[15:0];
        @(negedge clk);
        tick_en = 1'b1;
        n = 0;
        while (tick !== 1'b1 && n < 100) begin @(negedge clk); n++; end
        for (int r = 0; r < 2; r++) begin
          n = 0;
          do begin @(negedge clk); n++; end while (tick !== 1'b1 && n < 100);
          chk("R9 period", n, (p + 1) * (a + 1));
        end
      end
    end
    chk("R10 tick transfers", dac_code, 12'h777);
    tick_en = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule